// File: doc/BRIEF.md
# Programmable-Width Edge Pulse Generator

This block turns every transition of a level input, rising or falling, into a single high pulse. A conditioning stage paced by a slow "width" tick makes a lagged copy of the input. The output is the exclusive-OR of the live input and that copy. It is therefore high only while the two disagree, so the pulse width equals the lag of the conditioning stage. A second, optional conditioning stage on the XOR result is paced by its own "start" tick. It pushes the start of the pulse back by a set number of ticks.

Both ticks come from the one system clock through their own programmable dividers. The width stage offers a two-tick synchronizer or a four-tick stability filter. The start stage can be bypassed or set to either of the same two behaviours. A flag warns when the start stage is in use but paced more slowly than the width stage, because that ratio is not supported. The input `din` is taken to be synchronous to `clk`.

Top module: `edgepulse_gen`

## Requirements
- R1: After reset is released, with `din` low and a legal configuration, `pulse_o` is low and `ratio_err_o` is low.
- R2: With `cfg_sd_mode` = 0 (start stage bypassed), `pulse_o` rises in the same clock cycle as the change on `din`, for both rising and falling edges of `din`.
- R3: With `cfg_pl_filt` = 0 (synchronizer), an isolated edge gives a pulse whose length, before start conditioning, lies between N+1 and 2N clock cycles, where N is the effective width divider.
- R4: With `cfg_pl_filt` = 1 (filter), the pulse length before start conditioning lies between 3N+1 and 4N clock cycles.
- R5: Each divider produces one tick every D clock cycles, where D is the programmed value, and a programmed value of 0 acts as 1. So with a divide value of 0 or 1, the synchronizer width is exactly 2 cycles.
- R6: With `cfg_sd_mode` = 1 (start synchronizer), the pulse begins between M+1 and 2M cycles after the edge, where M is the effective start divider. Its length differs from the unconditioned length by at most M-1 cycles.
- R7: With `cfg_sd_mode` = 2 or 3 (start filter), the pulse begins between 3M+1 and 4M cycles after the edge, with the same length tolerance as R6.
- R8: `ratio_err_o` is high exactly when `cfg_sd_mode` is non-zero and the effective start divider is larger than the effective width divider. The flag follows the configuration inputs without delay.
- R9: Edges closer together than the pulse length may merge or shorten pulses. Once `din` has been steady long enough, `pulse_o` returns low, and the next isolated edge again gives a pulse that meets R3 to R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| din | input | 1 | Level input whose edges are turned into pulses |
| cfg_pl_filt | input | 1 | Width stage: 0 synchronizer (2 ticks), 1 filter (4 ticks) |
| cfg_pl_div | input | DIV_W | Width tick divider (0 acts as 1) |
| cfg_sd_mode | input | 2 | Start stage: 0 bypass, 1 synchronizer, 2 or 3 filter |
| cfg_sd_div | input | DIV_W | Start tick divider (0 acts as 1) |
| pulse_o | output | 1 | Edge pulse |
| ratio_err_o | output | 1 | Start tick slower than width tick while start stage is used |

## Verification
The hardest case to reach is the start filter. It only lets the pulse through when the XOR stays high across two consecutive start ticks, so a narrow width setting combined with a slow start divider silently swallows the pulse. This is a legal but uninteresting outcome. The random stimulus therefore bounds the start divider by the shortest pulse the chosen width mode can produce. This drives the filter right up to its acceptance limit without crossing it. A directed burst of back-to-back edges then exercises the merge case, followed by a clean edge to show the block recovers.

// File: rtl/edgepulse_pkg.sv
package edgepulse_pkg;
   typedef enum logic [1:0] {
      COND_OFF      = 2'd0,
      COND_SYNC     = 2'd1,
      COND_FILT     = 2'd2,
      COND_FILT_ALT = 2'd3
   } cond_mode_e;
endpackage

// File: rtl/edgepulse_tick.sv
module edgepulse_tick #(
   parameter int DIV_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

   logic [DIV_W-1:0] cnt;
   logic [DIV_W-1:0] lim;

   // a programmed zero behaves as a divide-by-one
   always_comb lim = (div == '0) ? '0 : div - ONE;

   assign tick = (cnt >= lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (tick) cnt <= '0;
      else           cnt <= cnt + ONE;
   end
endmodule

// File: rtl/edgepulse_cond.sv
module edgepulse_cond
   import edgepulse_pkg::*;
#(
   parameter bit ALLOW_OFF = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  cond_mode_e mode,
   input  logic       d,
   output logic       q
);
   logic s1, s2, f1, fq;
   logic staged;

   // two-stage synchronizer, then a stability filter that only
   // follows the synchronizer when it agrees with one tick later
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1 <= 1'b0;
         s2 <= 1'b0;
         f1 <= 1'b0;
         fq <= 1'b0;
      end else if (tick) begin
         s1 <= d;
         s2 <= s1;
         f1 <= s2;
         if (s2 == f1) fq <= s2;
      end
   end

   always_comb staged = (mode == COND_FILT || mode == COND_FILT_ALT) ? fq : s2;

   generate
      if (ALLOW_OFF) begin : g_bypass
         assign q = (mode == COND_OFF) ? d : staged;
      end else begin : g_always
         assign q = staged;
      end
   endgenerate
endmodule

// File: rtl/edgepulse_gen.sv
module edgepulse_gen
   import edgepulse_pkg::*;
#(
   parameter int DIV_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             din,
   input  logic             cfg_pl_filt,
   input  logic [DIV_W-1:0] cfg_pl_div,
   input  logic [1:0]       cfg_sd_mode,
   input  logic [DIV_W-1:0] cfg_sd_div,
   output logic             pulse_o,
   output logic             ratio_err_o
);
   generate
      if (DIV_W < 1 || DIV_W > 16) begin : g_bad_width
         $error("edgepulse_gen: DIV_W must be within 1..16");
      end
   endgenerate

   logic             pl_tick, sd_tick;
   logic             dly, xr;
   cond_mode_e       pl_mode, sd_mode;
   logic [DIV_W-1:0] pl_eff, sd_eff;

   assign pl_mode = cfg_pl_filt ? COND_FILT : COND_SYNC;
   assign sd_mode = cond_mode_e'(cfg_sd_mode);

   edgepulse_tick #(.DIV_W(DIV_W)) pl_div_i (
      .clk(clk), .rst_n(rst_n), .div(cfg_pl_div), .tick(pl_tick));

   edgepulse_tick #(.DIV_W(DIV_W)) sd_div_i (
      .clk(clk), .rst_n(rst_n), .div(cfg_sd_div), .tick(sd_tick));

   // lagged copy of the input: its lag is the pulse width
   edgepulse_cond #(.ALLOW_OFF(1'b0)) width_i (
      .clk(clk), .rst_n(rst_n), .tick(pl_tick), .mode(pl_mode),
      .d(din), .q(dly));

   assign xr = din ^ dly;

   // optional start postponement
   edgepulse_cond #(.ALLOW_OFF(1'b1)) start_i (
      .clk(clk), .rst_n(rst_n), .tick(sd_tick), .mode(sd_mode),
      .d(xr), .q(pulse_o));

   assign pl_eff      = (cfg_pl_div == '0) ? DIV_W'(1) : cfg_pl_div;
   assign sd_eff      = (cfg_sd_div == '0) ? DIV_W'(1) : cfg_sd_div;
   assign ratio_err_o = (cfg_sd_mode != 2'd0) && (sd_eff > pl_eff);
endmodule

// File: rtl/edgepulse_gen_chk.sv
module edgepulse_gen_chk #(
   parameter int DIV_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             din,
   input logic             cfg_pl_filt,
   input logic [DIV_W-1:0] cfg_pl_div,
   input logic [1:0]       cfg_sd_mode,
   input logic             pulse_o,
   input logic             ratio_err_o,
   input logic             pl_tick,
   input logic             sd_tick,
   input logic             dly
);
   AST_DLY_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(pl_tick) && $stable(cfg_pl_filt)) |-> $stable(dly)); // R3

   AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(pl_tick) && cfg_pl_div > DIV_W'(1) && $stable(cfg_pl_div)) |-> !pl_tick); // R5

   AST_BYPASS_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_sd_mode == 2'd0) |-> (pulse_o == (din ^ dly))); // R2

   AST_START_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_sd_mode != 2'd0 && $stable(cfg_sd_mode) && !$past(sd_tick)) |-> $stable(pulse_o)); // R6

   AST_ERR_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
      ratio_err_o |-> (cfg_sd_mode != 2'd0)); // R8
endmodule

bind edgepulse_gen edgepulse_gen_chk #(.DIV_W(DIV_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .din(din), .cfg_pl_filt(cfg_pl_filt),
   .cfg_pl_div(cfg_pl_div), .cfg_sd_mode(cfg_sd_mode), .pulse_o(pulse_o),
   .ratio_err_o(ratio_err_o), .pl_tick(pl_tick), .sd_tick(sd_tick), .dly(dly));

// File: tb/edgepulse_gen_tb_top.sv
`timescale 1ns/1ps
module edgepulse_gen_tb_top;
   localparam int DIV_W = 4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             din = 1'b0;
   logic             cfg_pl_filt = 1'b0;
   logic [DIV_W-1:0] cfg_pl_div = DIV_W'(1);
   logic [1:0]       cfg_sd_mode = 2'd0;
   logic [DIV_W-1:0] cfg_sd_div = DIV_W'(1);
   logic             pulse_o, ratio_err_o;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #10 clk = ~clk;

   edgepulse_gen #(.DIV_W(DIV_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .din(din), .cfg_pl_filt(cfg_pl_filt),
      .cfg_pl_div(cfg_pl_div), .cfg_sd_mode(cfg_sd_mode), .cfg_sd_div(cfg_sd_div),
      .pulse_o(pulse_o), .ratio_err_o(ratio_err_o));

   function automatic int eff(input int v);
      return (v == 0) ? 1 : v;
   endfunction

   function automatic int off_lo(input int sdm, input int m);
      if (sdm == 0) return 0;
      if (sdm == 1) return m + 1;
      return 3 * m + 1;
   endfunction

   function automatic int off_hi(input int sdm, input int m);
      if (sdm == 0) return 0;
      if (sdm == 1) return 2 * m;
      return 4 * m;
   endfunction

   task automatic check(input bit ok, input string req, input int act,
                        input int lo, input int hi);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=[%0d..%0d]", req, act, lo, hi);
      end
   endtask

   task automatic idle(input int cyc);
      for (int i = 0; i < cyc; i++) @(negedge clk);
   endtask

   task automatic set_cfg(input int pf, input int n, input int sdm, input int m);
      @(negedge clk);
      cfg_pl_filt = pf[0];
      cfg_pl_div  = DIV_W'(n);
      cfg_sd_mode = sdm[1:0];
      cfg_sd_div  = DIV_W'(m);
      idle(70);
   endtask

   // toggle din, then measure start offset and width in clock cycles
   task automatic run_edge(input int pf, input int n, input int sdm, input int m);
      int off, wid, k, mm, lo, hi;
      string wtag, otag;
      off = -1; wid = 0;
      @(negedge clk);
      din = ~din;
      #1;
      for (int idx = 0; idx < 200; idx++) begin
         if (idx > 0) @(negedge clk);
         if (pulse_o) begin
            if (off < 0) off = idx;
            wid++;
         end else if (off >= 0) begin
            break;
         end
      end
      k    = pf ? 4 : 2;
      mm   = (sdm == 0) ? 1 : eff(m);
      otag = (sdm == 0) ? "R2 start" : ((sdm == 1) ? "R6 start" : "R7 start");
      check(off >= off_lo(sdm, eff(m)) && off <= off_hi(sdm, eff(m)), otag, off,
            off_lo(sdm, eff(m)), off_hi(sdm, eff(m)));
      lo   = (k - 1) * eff(n) + 1 - (mm - 1);
      hi   = k * eff(n) + (mm - 1);
      wtag = pf ? "R4 width" : "R3 width";
      check(wid >= lo && wid <= hi, wtag, wid, lo, hi);
      idle(70);
   endtask

   initial begin
      #4000000;
      n_fail++;
      n_checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      int pf, n, sdm, m, k, wmin, mmax;
      void'($urandom(32'h00C0FFEE));
      idle(5);
      @(negedge clk);
      rst_n = 1'b1;
      idle(3);
      // R1: quiet after reset
      check(pulse_o == 1'b0, "R1 pulse", int'(pulse_o), 0, 0);
      check(ratio_err_o == 1'b0, "R1 err", int'(ratio_err_o), 0, 0);

      // directed: fastest width, both polarities, bypassed start (R2, R3)
      set_cfg(0, 1, 0, 1);
      run_edge(0, 1, 0, 1);
      run_edge(0, 1, 0, 1);
      // filter width (R4)
      set_cfg(1, 1, 0, 1);
      run_edge(1, 1, 0, 1);
      run_edge(1, 1, 0, 1);
      // R5: divide value 0 behaves as 1
      set_cfg(0, 0, 0, 0);
      run_edge(0, 0, 0, 0);
      run_edge(0, 0, 0, 0);

      // R8: illegal and legal ratios
      set_cfg(0, 2, 1, 3);
      check(ratio_err_o == 1'b1, "R8 slow start", int'(ratio_err_o), 1, 1);
      set_cfg(0, 2, 0, 3);
      check(ratio_err_o == 1'b0, "R8 bypass", int'(ratio_err_o), 0, 0);
      set_cfg(0, 0, 2, 1);
      check(ratio_err_o == 1'b0, "R8 zero as one", int'(ratio_err_o), 0, 0);
      set_cfg(0, 1, 3, 0);
      check(ratio_err_o == 1'b0, "R8 equal", int'(ratio_err_o), 0, 0);

      // R9: back-to-back edges, then recovery
      set_cfg(0, 3, 0, 1);
      @(negedge clk); din = ~din;
      @(negedge clk); din = ~din;
      @(negedge clk); din = ~din;
      idle(60);
      check(pulse_o == 1'b0, "R9 settle", int'(pulse_o), 0, 0);
      run_edge(0, 3, 0, 1);

      // constrained random over all modes
      for (int t = 0; t < 24; t++) begin
         pf   = int'($urandom_range(0, 1));
         n    = int'($urandom_range(1, 6));
         sdm  = int'($urandom_range(0, 3));
         k    = pf ? 4 : 2;
         wmin = (k - 1) * n + 1;
         mmax = (sdm >= 2) ? ((wmin / 3 < 1) ? 1 : wmin / 3) : n;
         if (mmax > n) mmax = n;
         m    = int'($urandom_range(1, mmax));
         set_cfg(pf, n, sdm, m);
         check(ratio_err_o == 1'b0, "R8 legal", int'(ratio_err_o), 0, 0);
         run_edge(pf, n, sdm, m);
         run_edge(pf, n, sdm, m);
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule